// File: doc/BRIEF.md
# Operate Microinstruction Execution Unit

This block carries out the operate class of a 12-bit minicomputer instruction set: instructions whose top three bits are all ones. Such an instruction holds no address. Instead, each of its low bits enables one small operation on the accumulator (AC) and the one-bit link. Bit 8 picks between two groups. The first group clears, complements, rotates and increments. The second group tests conditions for a skip, clears AC, merges in the front-panel switch register and can stop the machine.

The surrounding datapath presents the instruction, the current AC and link, and the switch register, then pulses an execute strobe. One clock later the block holds the new AC and link. For one cycle it raises a skip request, which tells the program-counter logic to add one more increment. A halt request, once raised, stays high until the continue input is asserted. Extended-arithmetic operate codes are accepted and have no effect.

Top module: `opr_exec_unit`

## Requirements
- R1: With bit 8 clear, the clears run before the complements: bit 7 zeroes AC, bit 6 zeroes the link, then bit 5 inverts AC and bit 4 inverts the link (so 7240 octal yields AC=7777).
- R2: Bit 3 rotates the 13-bit word formed by the link (top) and AC right by one, and bit 2 rotates it left by one. When both are set, the right rotate is applied first, and together they leave the word unchanged.
- R3: Bit 1 makes each selected rotate act twice. With no rotate selected, bit 1 alone changes nothing.
- R4: Bit 0 adds one to AC modulo 4096 after all rotates. A carry out of AC bit 11 inverts the link.
- R5: With bit 8 set, the skip conditions are: bit 6 tests AC bit 11 set (negative), bit 5 tests AC equal to zero, and bit 4 tests link equal to one. Any selected condition that is true requests a skip.
- R6: Group-2 bit 3 reverses the sense, so a skip happens only when no selected condition is true. With bit 3 set and bits 6..4 clear, the skip is unconditional.
- R7: In group 2 the skip is decided from the incoming AC. Bit 7 then zeroes AC, bit 2 then ORs the switch register into AC, and the link passes through unchanged.
- R8: Group-2 bit 1 sets halt_req. The request stays high until cont_in is sampled high; a new halt in the same cycle takes priority over cont_in.
- R9: Group-2 bit 0 (extended arithmetic) has no effect on AC, link, skip or halt.
- R10: ac_out and link_out load only on a clock edge where exec_en is high and instr[11:9]=111. Otherwise they hold, including when exec_en is high with any other opcode.
- R11: skip_req is high for exactly the one cycle after an execute that requests a skip, and is low in every other cycle.
- R12: While rst_n is low, ac_out, link_out, skip_req and halt_req are all zero. Reset takes effect at once and is released two clock edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute strobe for the instruction on instr |
| instr | input | 12 | Instruction word |
| ac_in | input | 12 | Current accumulator value |
| link_in | input | 1 | Current link bit |
| sw_reg | input | 12 | Front-panel switch register |
| cont_in | input | 1 | Continue; clears a pending halt |
| ac_out | output | 12 | Registered new accumulator |
| link_out | output | 1 | Registered new link |
| skip_req | output | 1 | One-cycle request for an extra PC increment |
| halt_req | output | 1 | Held halt request |

## Verification
The bench builds the unit with its default 12-bit word, which is the only width at which the operate bit layout and octal codes such as 7777 mean what the requirements say. At this width the wrap of 7777 to 0000 with a link flip, the sign test on bit 11, and the double rotates that carry a bit through the link into bit 11 can all be reached directly. Each vector's expected AC, link, skip and halt values come from the requirement rules, worked out by hand in octal.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int IR_W = 12;
  localparam logic [2:0] OPC_OPERATE = 3'b111;

  // shared bit positions (group select, plus group-1 controls)
  localparam int B_GRP   = 8;
  localparam int B_CLRAC = 7;
  localparam int B_CLRLK = 6;
  localparam int B_INVAC = 5;
  localparam int B_INVLK = 4;
  localparam int B_ROTR  = 3;
  localparam int B_ROTL  = 2;
  localparam int B_DBL   = 1;
  localparam int B_INC   = 0;
  // group-2 positions
  localparam int B_TNEG  = 6;
  localparam int B_TZERO = 5;
  localparam int B_TLINK = 4;
  localparam int B_REV   = 3;
  localparam int B_MERGE = 2;
  localparam int B_STOP  = 1;
  localparam int B_EXTA  = 0;

  typedef struct packed {
    logic clr_ac;
    logic clr_lk;
    logic inv_ac;
    logic inv_lk;
    logic rot_r;
    logic rot_l;
    logic dbl;
    logic inc;
  } g1_ctl_t;

  function automatic g1_ctl_t g1_decode(input logic [IR_W-1:0] ir);
    g1_ctl_t c;
    c.clr_ac = ir[B_CLRAC];
    c.clr_lk = ir[B_CLRLK];
    c.inv_ac = ir[B_INVAC];
    c.inv_lk = ir[B_INVLK];
    c.rot_r  = ir[B_ROTR];
    c.rot_l  = ir[B_ROTL];
    c.dbl    = ir[B_DBL];
    c.inc    = ir[B_INC];
    return c;
  endfunction
endpackage

// File: rtl/opr_group1.sv
module opr_group1 import opr_pkg::*; #(
  parameter int WORD_W = 12
) (
  input  g1_ctl_t           ctl,
  input  logic [WORD_W-1:0] ac_i,
  input  logic              lk_i,
  output logic [WORD_W-1:0] ac_o,
  output logic              lk_o
);
  localparam int LW     = WORD_W + 1;
  localparam int PASSES = 2;

  logic [WORD_W-1:0] ac_clr, ac_inv;
  logic              lk_clr, lk_inv;

  // R1: clears first, then complements
  always_comb begin
    ac_clr = ctl.clr_ac ? '0 : ac_i;
    lk_clr = ctl.clr_lk ? 1'b0 : lk_i;
    ac_inv = ctl.inv_ac ? ~ac_clr : ac_clr;
    lk_inv = ctl.inv_lk ? ~lk_clr : lk_clr;
  end

  // R2/R3: rotate passes on {link, AC}; the second pass only under the doubling bit
  logic [PASSES:0][LW-1:0] stage;
  assign stage[0] = {lk_inv, ac_inv};

  for (genvar p = 0; p < PASSES; p++) begin : g_pass
    logic [LW-1:0] after_r, after_l;
    always_comb begin
      after_r = ctl.rot_r ? {stage[p][0], stage[p][LW-1:1]} : stage[p];
      after_l = ctl.rot_l ? {after_r[LW-2:0], after_r[LW-1]} : after_r;
    end
    if (p == 0) begin : g_first
      assign stage[p+1] = after_l;
    end else begin : g_more
      assign stage[p+1] = ctl.dbl ? after_l : stage[p];
    end
  end

  // R4: increment last, carry flips the link
  logic [WORD_W:0] sum;
  always_comb begin
    sum  = {1'b0, stage[PASSES][WORD_W-1:0]} + {{WORD_W{1'b0}}, ctl.inc};
    ac_o = sum[WORD_W-1:0];
    lk_o = stage[PASSES][LW-1] ^ sum[WORD_W];
  end
endmodule

// File: rtl/opr_group2.sv
module opr_group2 import opr_pkg::*; #(
  parameter int WORD_W = 12
) (
  input  logic [IR_W-1:0]   ir,
  input  logic [WORD_W-1:0] ac_i,
  input  logic              lk_i,
  input  logic [WORD_W-1:0] sw_i,
  output logic [WORD_W-1:0] ac_o,
  output logic              skip_o,
  output logic              halt_o
);
  localparam int NCOND = 3;

  logic [NCOND-1:0] sel, truth;
  logic             any_hit;
  logic [WORD_W-1:0] ac_cleared;

  always_comb begin
    // R5: conditions are sampled from AC before any clear
    sel     = {ir[B_TNEG], ir[B_TZERO], ir[B_TLINK]};
    truth   = {ac_i[WORD_W-1], (ac_i == '0), lk_i};
    any_hit = |(sel & truth);
    // R6: reverse sense
    skip_o  = ir[B_REV] ? ~any_hit : any_hit;
    // R7: clear then merge switches
    ac_cleared = ir[B_CLRAC] ? '0 : ac_i;
    ac_o       = ir[B_MERGE] ? (ac_cleared | sw_i) : ac_cleared;
    // R8 request; R9 extended-arithmetic bit deliberately unused
    halt_o  = ir[B_STOP];
  end

  logic unused_exta;
  assign unused_exta = ir[B_EXTA];
endmodule

// File: rtl/opr_rst_sync.sv
module opr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end
  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/opr_exec_unit.sv
module opr_exec_unit import opr_pkg::*; #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [IR_W-1:0]   instr,
  input  logic [WORD_W-1:0] ac_in,
  input  logic              link_in,
  input  logic [WORD_W-1:0] sw_reg,
  input  logic              cont_in,
  output logic [WORD_W-1:0] ac_out,
  output logic              link_out,
  output logic              skip_req,
  output logic              halt_req
);
  logic srst_n;
  opr_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  logic is_opr, grp2, fire;
  assign is_opr = (instr[IR_W-1:IR_W-3] == OPC_OPERATE);
  assign grp2   = instr[B_GRP];
  assign fire   = exec_en && is_opr;

  logic [WORD_W-1:0] g1_ac, g2_ac;
  logic              g1_lk, g2_skip, g2_halt;

  opr_group1 #(.WORD_W(WORD_W)) u_g1 (
    .ctl(g1_decode(instr)), .ac_i(ac_in), .lk_i(link_in),
    .ac_o(g1_ac), .lk_o(g1_lk)
  );

  opr_group2 #(.WORD_W(WORD_W)) u_g2 (
    .ir(instr), .ac_i(ac_in), .lk_i(link_in), .sw_i(sw_reg),
    .ac_o(g2_ac), .skip_o(g2_skip), .halt_o(g2_halt)
  );

  logic [WORD_W-1:0] ac_q, ac_d;
  logic              lk_q, lk_d, skip_q, skip_d, halt_q, halt_d;

  // next state
  always_comb begin
    ac_d   = ac_q;
    lk_d   = lk_q;
    skip_d = 1'b0;
    halt_d = cont_in ? 1'b0 : halt_q;
    if (fire) begin
      if (grp2) begin
        ac_d   = g2_ac;
        lk_d   = link_in;
        skip_d = g2_skip;
        if (g2_halt) halt_d = 1'b1;
      end else begin
        ac_d = g1_ac;
        lk_d = g1_lk;
      end
    end
  end

  // registers: async assert, synchronous release via srst_n
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ac_q   <= '0;
      lk_q   <= 1'b0;
      skip_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (fire) begin
        ac_q <= ac_d;
        lk_q <= lk_d;
      end
      skip_q <= skip_d;
      halt_q <= halt_d;
    end
  end

  assign ac_out   = ac_q;
  assign link_out = lk_q;
  assign skip_req = skip_q;
  assign halt_req = halt_q;

  // R10: without an operate execute the outputs hold
  p_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !(exec_en && is_opr) |=> ($stable(ac_out) && $stable(link_out)));

  // R11: a skip only follows an execute
  p_skip_after_exec_r11: assert property (@(posedge clk) disable iff (!srst_n)
    skip_req |-> $past(exec_en && is_opr && grp2));

  // R4: all-ones AC with a bare increment wraps and flips the link
  p_wrap_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (exec_en && is_opr && !grp2 && instr[7:0] == 8'b0000_0001 && ac_in == '1)
    |=> (ac_out == '0 && link_out != $past(link_in)));

  // R6: reverse with nothing selected always skips
  p_rev_none_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (exec_en && is_opr && grp2 && instr[6:3] == 4'b0001) |=> skip_req);

  // R7: group 2 leaves the link alone
  p_link_keep_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (exec_en && is_opr && grp2) |=> (link_out == $past(link_in)));

  // R8: halt persists without continue, continue clears it
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (halt_req && !cont_in) |=> halt_req);
  p_cont_clear_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (cont_in && !(exec_en && is_opr && grp2 && instr[B_STOP])) |=> !halt_req);
endmodule

// File: tb/opr_exec_unit_bench.sv
`timescale 1ns/1ps
module opr_exec_unit_bench;
  localparam int W = 12;
  localparam int NV = 34;

  logic         clk = 1'b0;
  logic         rst_n, exec_en, link_in, cont_in;
  logic [11:0]  instr;
  logic [W-1:0] ac_in, sw_reg, ac_out;
  logic         link_out, skip_req, halt_req;

  always #10 clk = ~clk;

  opr_exec_unit #(.WORD_W(W)) u_opr_exec_unit (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
    .ac_in(ac_in), .link_in(link_in), .sw_reg(sw_reg), .cont_in(cont_in),
    .ac_out(ac_out), .link_out(link_out), .skip_req(skip_req), .halt_req(halt_req)
  );

  // {instr, ac, link, sw, exp_ac, exp_link, exp_skip, exp_halt}
  localparam logic [51:0] VEC [NV] = '{
    {12'o7200, 12'o5555, 1'b1, 12'o0000, 12'o0000, 1'b1, 1'b0, 1'b0}, // R1
    {12'o7100, 12'o1234, 1'b1, 12'o0000, 12'o1234, 1'b0, 1'b0, 1'b0}, // R1
    {12'o7040, 12'o1234, 1'b0, 12'o0000, 12'o6543, 1'b0, 1'b0, 1'b0}, // R1
    {12'o7020, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0, 1'b0}, // R1
    {12'o7240, 12'o1234, 1'b0, 12'o0000, 12'o7777, 1'b0, 1'b0, 1'b0}, // R1
    {12'o7120, 12'o0123, 1'b0, 12'o0000, 12'o0123, 1'b1, 1'b0, 1'b0}, // R1
    {12'o7010, 12'o0001, 1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0, 1'b0}, // R2
    {12'o7004, 12'o4000, 1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0, 1'b0}, // R2
    {12'o7014, 12'o1234, 1'b1, 12'o0000, 12'o1234, 1'b1, 1'b0, 1'b0}, // R2
    {12'o7012, 12'o0001, 1'b0, 12'o0000, 12'o4000, 1'b0, 1'b0, 1'b0}, // R3
    {12'o7006, 12'o4000, 1'b0, 12'o0000, 12'o0001, 1'b0, 1'b0, 1'b0}, // R3
    {12'o7002, 12'o1234, 1'b1, 12'o0000, 12'o1234, 1'b1, 1'b0, 1'b0}, // R3
    {12'o7001, 12'o7777, 1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0, 1'b0}, // R4
    {12'o7001, 12'o0010, 1'b1, 12'o0000, 12'o0011, 1'b1, 1'b0, 1'b0}, // R4
    {12'o7041, 12'o0005, 1'b0, 12'o0000, 12'o7773, 1'b0, 1'b0, 1'b0}, // R4
    {12'o7011, 12'o0001, 1'b0, 12'o0000, 12'o0001, 1'b1, 1'b0, 1'b0}, // R4
    {12'o7500, 12'o4000, 1'b0, 12'o0000, 12'o4000, 1'b0, 1'b1, 1'b0}, // R5
    {12'o7500, 12'o3777, 1'b0, 12'o0000, 12'o3777, 1'b0, 1'b0, 1'b0}, // R5
    {12'o7440, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b0, 1'b1, 1'b0}, // R5
    {12'o7420, 12'o0005, 1'b1, 12'o0000, 12'o0005, 1'b1, 1'b1, 1'b0}, // R5
    {12'o7560, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b0, 1'b1, 1'b0}, // R5
    {12'o7510, 12'o3777, 1'b0, 12'o0000, 12'o3777, 1'b0, 1'b1, 1'b0}, // R6
    {12'o7510, 12'o4000, 1'b0, 12'o0000, 12'o4000, 1'b0, 1'b0, 1'b0}, // R6
    {12'o7450, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b0, 1'b0, 1'b0}, // R6
    {12'o7410, 12'o1234, 1'b0, 12'o0000, 12'o1234, 1'b0, 1'b1, 1'b0}, // R6
    {12'o7400, 12'o1234, 1'b0, 12'o0000, 12'o1234, 1'b0, 1'b0, 1'b0}, // R6
    {12'o7570, 12'o0005, 1'b0, 12'o0000, 12'o0005, 1'b0, 1'b1, 1'b0}, // R6
    {12'o7430, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b0, 1'b1, 1'b0}, // R6
    {12'o7640, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b0, 1'b1, 1'b0}, // R7
    {12'o7640, 12'o0005, 1'b1, 12'o0000, 12'o0000, 1'b1, 1'b0, 1'b0}, // R7
    {12'o7404, 12'o0101, 1'b0, 12'o1010, 12'o1111, 1'b0, 1'b0, 1'b0}, // R7
    {12'o7604, 12'o7000, 1'b0, 12'o0123, 12'o0123, 1'b0, 1'b0, 1'b0}, // R7
    {12'o7402, 12'o0042, 1'b0, 12'o0000, 12'o0042, 1'b0, 1'b0, 1'b1}, // R8
    {12'o7401, 12'o0042, 1'b1, 12'o0000, 12'o0042, 1'b1, 1'b0, 1'b0}  // R9
  };

  localparam string VTAG [NV] = '{
    "R1","R1","R1","R1","R1","R1","R2","R2","R2","R3","R3","R3",
    "R4","R4","R4","R4","R5","R5","R5","R5","R5","R6","R6","R6",
    "R6","R6","R6","R6","R7","R7","R7","R7","R8","R9"};

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0o expected=%0o", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [11:0] ir, input logic [W-1:0] a, input logic l, input logic [W-1:0] s);
    @(negedge clk);
    instr = ir; ac_in = a; link_in = l; sw_reg = s; exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  task automatic pulse_cont();
    cont_in = 1'b1;
    @(negedge clk);
    cont_in = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; exec_en = 1'b0; cont_in = 1'b0; link_in = 1'b0;
    instr = '0; ac_in = '0; sw_reg = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "ac_out", 32'(ac_out), 0);
    chk("R12", "link_out", 32'(link_out), 0);
    chk("R12", "skip_req", 32'(skip_req), 0);
    chk("R12", "halt_req", 32'(halt_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      v = VEC[i];
      run_op(v[51:40], v[39:28], v[27], v[26:15]);
      chk(VTAG[i], "ac_out", 32'(ac_out), 32'(v[14:3]));
      chk(VTAG[i], "link_out", 32'(link_out), 32'(v[2]));
      chk(VTAG[i], "skip_req", 32'(skip_req), 32'(v[1]));
      chk(VTAG[i], "halt_req", 32'(halt_req), 32'(v[0]));
      pulse_cont();
    end

    // R10: no strobe, outputs hold
    run_op(12'o7200, 12'o0000, 1'b1, 12'o0000); // ac=0000 link=1
    instr = 12'o7041; ac_in = 12'o3333; link_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "ac_out hold", 32'(ac_out), 0);
    chk("R10", "link_out hold", 32'(link_out), 1);
    // R10: non-operate opcode with strobe is ignored
    run_op(12'o1234, 12'o5555, 1'b0, 12'o0000);
    chk("R10", "ac_out non-opr", 32'(ac_out), 0);
    chk("R10", "link_out non-opr", 32'(link_out), 1);
    chk("R10", "skip_req non-opr", 32'(skip_req), 0);

    // R11: skip pulse lasts one cycle
    run_op(12'o7410, 12'o0007, 1'b0, 12'o0000);
    chk("R11", "skip first cycle", 32'(skip_req), 1);
    @(negedge clk);
    chk("R11", "skip second cycle", 32'(skip_req), 0);

    // R8: halt held until continue; halt beats continue in same cycle
    run_op(12'o7402, 12'o0000, 1'b0, 12'o0000);
    repeat (3) @(negedge clk);
    chk("R8", "halt held", 32'(halt_req), 1);
    pulse_cont();
    chk("R8", "halt cleared", 32'(halt_req), 0);
    @(negedge clk);
    instr = 12'o7402; exec_en = 1'b1; cont_in = 1'b1;
    @(negedge clk);
    exec_en = 1'b0; cont_in = 1'b0;
    chk("R8", "halt wins over continue", 32'(halt_req), 1);

    // R12: asynchronous reset mid-run
    run_op(12'o7040, 12'o0000, 1'b1, 12'o0000); // ac=7777
    #3 rst_n = 1'b0;
    #2;
    chk("R12", "ac_out async", 32'(ac_out), 0);
    chk("R12", "link_out async", 32'(link_out), 0);
    chk("R12", "halt_req async", 32'(halt_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    instr = 12'o7040; ac_in = 12'o0000; exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
    chk("R12", "held in reset one edge after release", 32'(ac_out), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule